// File: doc/BRIEF.md
# Compound frame walker

The walker reads a table of frame entries out of a word-addressed memory and hands each entry on, one at a time, as a decoded transfer request. An entry takes four consecutive 32-bit words: an upper address word, a lower address word, a flags-and-length word, and a spare word that is never fetched. From these the walker forms a 40-bit byte address, a 20-bit length, a final marker and an extension marker, and labels the entry with its position and role.

Entry 0 always describes the command block. The walker fetches the first word of that block to learn the operation, because the operation decides how many destination entries follow. A two-destination parity operation gives entries 1 and 2 the destination role. Every other operation, including copy and single parity, has one destination at entry 1. All later entries are sources. The walk ends after the entry that carries the final marker. It aborts with an error when a data entry has zero length, or when the last allowed entry goes by without the final marker. The data transfers themselves are carried out by a downstream engine, which takes entries from the valid/ready output.

Top module: `frame_walker`

## Requirements
- R1: While reset is asserted and after its release, `ent_valid`, `busy`, `done`, `err`, `mem_rd_en` are 0 and `err_code` is 0.
- R2: Entry fields: `ent_addr` = {bits 7:0 of word 0, word 1}, and bits 31:8 of word 0 are ignored. `ent_len` = bits 19:0 of word 2, `ent_final` = bit 30 of word 2, `ent_ext` = bit 31 of word 2, and bits 29:20 are ignored.
- R3: Entry i occupies words `base_addr`+4i to +4i+3. The spare word (offset 3) is never read. `ent_index` carries i.
- R4: Role encoding is 0 = command, 1 = destination, 2 = source. Index 0 is command and index 1 is destination. Index 2 is destination only when the opcode equals 0x1B, otherwise source. Indices 3 and up are sources.
- R5: The opcode is bits 31:27 of the memory word at word address `ent_addr[MA_W+1:2]` of entry 0. Read data is due one cycle after `mem_rd_en`.
- R6: While `ent_valid` is high and `ent_ready` is low, the output entry holds unchanged.
- R7: The handshake of an entry with the final marker ends the walk. `done` pulses in the next cycle and `busy` is low from then on.
- R8: When entry MAX_ENT-1 (default 18) is accepted without the final marker, `err` pulses in the next cycle with `err_code` = 2.
- R9: A data entry (index 1 or above) with zero length is not presented. `err` pulses with `err_code` = 1. The length of entry 0 is not checked.
- R10: Entry 0 becomes valid 6 cycles after the clock edge that samples `start`. Each later entry becomes valid 4 cycles after the handshake edge of the previous one. A length error pulses `err` 4 cycles after the previous handshake.
- R11: `start` is ignored while `busy` is high.
- R12: `done` and `err` last one cycle each. `err_code` holds its value until the next accepted `start`, which clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk at `base_addr` |
| base_addr | input | MA_W | Word address of entry 0 |
| busy | output | 1 | Walk in progress |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | MA_W | Memory word address |
| mem_rd_data | input | 32 | Read data, one cycle after request |
| ent_valid | output | 1 | Decoded entry available |
| ent_ready | input | 1 | Consumer accepts entry |
| ent_index | output | IDX_W | Entry position in table |
| ent_role | output | 2 | 0 command, 1 destination, 2 source |
| ent_addr | output | 40 | Entry byte address |
| ent_len | output | 20 | Entry length in bytes |
| ent_final | output | 1 | Final marker of entry |
| ent_ext | output | 1 | Extension marker of entry |
| done | output | 1 | Walk ended normally (pulse) |
| err | output | 1 | Walk aborted (pulse) |
| err_code | output | 2 | 1 zero length, 2 no final marker |

## Verification
Entry 0 is due exactly 6 cycles after `start` is sampled and every later entry exactly 4 cycles after the previous handshake. The terminating `done` or `err` pulse is due one cycle after the last handshake, or 4 cycles after it in the case of a zero-length entry. The bench holds a reference that counts these delays down from the stimulus edges, using the ready value it drove. Every cycle it compares `ent_valid`, the entry fields, `busy`, `done`, `err` and `err_code` at the falling edge. A late or early output therefore shows up in the cycle where it appears, not only at the end. Random stalls on `ent_ready` keep an entry waiting, so the hold rule is exercised on the same per-cycle comparison.

// File: rtl/fw_pkg.sv
package fw_pkg;

  typedef enum logic [1:0] {
    ROLE_CMD = 2'd0,
    ROLE_DST = 2'd1,
    ROLE_SRC = 2'd2
  } role_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HI,
    ST_RD_LO,
    ST_RD_FL,
    ST_CAP_FL,
    ST_RD_CMD,
    ST_CAP_CMD,
    ST_SHOW
  } walk_state_e;

  localparam int ADDR_W     = 40;
  localparam int ADDR_HI_W  = ADDR_W - 32;
  localparam int LEN_W      = 20;
  localparam int FIN_BIT    = 30;
  localparam int EXT_BIT    = 31;
  localparam int OPC_MSB    = 31;
  localparam int OPC_LSB    = 27;
  localparam int OPC_W      = OPC_MSB - OPC_LSB + 1;
  localparam int WORDS_PER_ENT = 4;

  localparam logic [OPC_W-1:0] OPC_MOVE = 5'h08;
  localparam logic [OPC_W-1:0] OPC_XOR  = 5'h1A;
  localparam logic [OPC_W-1:0] OPC_PQ   = 5'h1B;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_LEN  = 2'd1;
  localparam logic [1:0] ERR_OVR  = 2'd2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              fin;
    logic              ext;
  } entry_t;

endpackage

// File: rtl/fw_entry_decode.sv
module fw_entry_decode
  import fw_pkg::*;
(
  input  logic [31:0] hi_word,
  input  logic [31:0] lo_word,
  input  logic [31:0] flag_word,
  output entry_t      fields,
  output logic        len_zero
);

  logic unused_bits;

  assign fields.addr = {hi_word[ADDR_HI_W-1:0], lo_word};
  assign fields.len  = flag_word[LEN_W-1:0];
  assign fields.fin  = flag_word[FIN_BIT];
  assign fields.ext  = flag_word[EXT_BIT];
  assign len_zero    = (flag_word[LEN_W-1:0] == '0);

  assign unused_bits = ^{hi_word[31:ADDR_HI_W], flag_word[FIN_BIT-1:LEN_W]};

endmodule

// File: rtl/fw_role_map.sv
module fw_role_map
  import fw_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter logic [OPC_W-1:0] DUAL_DST_OPC = OPC_PQ
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [OPC_W-1:0] opcode,
  output logic [1:0]       role
);

  role_e role_sel;

  always_comb begin
    if (idx == IDX_W'(0)) begin
      role_sel = ROLE_CMD;
    end else if (idx == IDX_W'(1)) begin
      role_sel = ROLE_DST;
    end else if ((idx == IDX_W'(2)) && (opcode == DUAL_DST_OPC)) begin
      role_sel = ROLE_DST;
    end else begin
      role_sel = ROLE_SRC;
    end
  end

  assign role = role_sel;

endmodule

// File: rtl/frame_walker.sv
module frame_walker
  import fw_pkg::*;
#(
  parameter int MA_W    = 16,
  parameter int MAX_ENT = 19,
  localparam int IDX_W  = $clog2(MAX_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MA_W-1:0]   base_addr,
  output logic              busy,
  output logic              mem_rd_en,
  output logic [MA_W-1:0]   mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              ent_valid,
  input  logic              ent_ready,
  output logic [IDX_W-1:0]  ent_index,
  output logic [1:0]        ent_role,
  output logic [39:0]       ent_addr,
  output logic [19:0]       ent_len,
  output logic              ent_final,
  output logic              ent_ext,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_code
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_ENT - 1);

  walk_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [MA_W-1:0]  ebase_q, ebase_d;
  logic [31:0]      hi_q, lo_q, fl_q;
  logic [OPC_W-1:0] opc_q;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [1:0]       code_q, code_d;
  logic             hi_en, lo_en, fl_en, opc_en;

  logic [31:0]      flag_src;
  entry_t           ent;
  logic             ent_len_zero;

  // Flags word is taken straight from memory in the cycle it arrives,
  // so the length check can steer the next state without a bubble.
  assign flag_src = (state_q == ST_CAP_FL) ? mem_rd_data : fl_q;

  fw_entry_decode u_decode (
    .hi_word   (hi_q),
    .lo_word   (lo_q),
    .flag_word (flag_src),
    .fields    (ent),
    .len_zero  (ent_len_zero)
  );

  fw_role_map #(
    .IDX_W        (IDX_W),
    .DUAL_DST_OPC (OPC_PQ)
  ) u_role (
    .idx    (idx_q),
    .opcode (opc_q),
    .role   (ent_role)
  );

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    ebase_d     = ebase_q;
    done_d      = 1'b0;
    err_d       = 1'b0;
    code_d      = code_q;
    hi_en       = 1'b0;
    lo_en       = 1'b0;
    fl_en       = 1'b0;
    opc_en      = 1'b0;
    mem_rd_en   = 1'b0;
    mem_rd_addr = ebase_q;

    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RD_HI;
          idx_d   = '0;
          ebase_d = base_addr;
          code_d  = ERR_NONE;
        end
      end
      ST_RD_HI: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = ebase_q;
        state_d     = ST_RD_LO;
      end
      ST_RD_LO: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = ebase_q + MA_W'(1);
        hi_en       = 1'b1;
        state_d     = ST_RD_FL;
      end
      ST_RD_FL: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = ebase_q + MA_W'(2);
        lo_en       = 1'b1;
        state_d     = ST_CAP_FL;
      end
      ST_CAP_FL: begin
        fl_en = 1'b1;
        if (idx_q == '0) begin
          state_d = ST_RD_CMD;
        end else if (ent_len_zero) begin
          state_d = ST_IDLE;
          err_d   = 1'b1;
          code_d  = ERR_LEN;
        end else begin
          state_d = ST_SHOW;
        end
      end
      ST_RD_CMD: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = ent.addr[MA_W+1:2];
        state_d     = ST_CAP_CMD;
      end
      ST_CAP_CMD: begin
        opc_en  = 1'b1;
        state_d = ST_SHOW;
      end
      ST_SHOW: begin
        if (ent_ready) begin
          if (ent.fin) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else if (idx_q == LAST_IDX) begin
            state_d = ST_IDLE;
            err_d   = 1'b1;
            code_d  = ERR_OVR;
          end else begin
            state_d = ST_RD_HI;
            idx_d   = idx_q + IDX_W'(1);
            ebase_d = ebase_q + MA_W'(WORDS_PER_ENT);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ebase_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= ERR_NONE;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      ebase_q <= ebase_d;
      done_q  <= done_d;
      err_q   <= err_d;
      code_q  <= code_d;
    end
  end

  // Entry word registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      fl_q  <= '0;
      opc_q <= '0;
    end else begin
      if (hi_en)  hi_q  <= mem_rd_data;
      if (lo_en)  lo_q  <= mem_rd_data;
      if (fl_en)  fl_q  <= mem_rd_data;
      if (opc_en) opc_q <= mem_rd_data[OPC_MSB:OPC_LSB];
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign ent_valid = (state_q == ST_SHOW);
  assign ent_index = idx_q;
  assign ent_addr  = ent.addr;
  assign ent_len   = ent.len;
  assign ent_final = ent.fin;
  assign ent_ext   = ent.ext;
  assign done      = done_q;
  assign err       = err_q;
  assign err_code  = code_q;

endmodule

// File: rtl/fw_checker.sv
module fw_checker #(
  parameter int MAX_ENT = 19,
  parameter int IDX_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mem_rd_en,
  input logic             ent_valid,
  input logic             ent_ready,
  input logic [IDX_W-1:0] ent_index,
  input logic [1:0]       ent_role,
  input logic [39:0]      ent_addr,
  input logic [19:0]      ent_len,
  input logic             ent_final,
  input logic             done,
  input logic             err
);

  // R6
  hold_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_addr) && $stable(ent_len)
                                   && $stable(ent_index) && $stable(ent_role) && $stable(ent_final)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R7
  end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err) |-> (!busy && !(done && err)));

  // R4
  cmd_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> ((ent_index == '0) == (ent_role == 2'd0)));

  // R9
  nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_index != '0) |-> (ent_len != '0));

  // R8
  index_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (int'(ent_index) < MAX_ENT));

  // R3
  no_read_on_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (busy && !mem_rd_en));

endmodule

bind frame_walker fw_checker #(
  .MAX_ENT (MAX_ENT),
  .IDX_W   (IDX_W)
) u_fw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mem_rd_en (mem_rd_en),
  .ent_valid (ent_valid),
  .ent_ready (ent_ready),
  .ent_index (ent_index),
  .ent_role  (ent_role),
  .ent_addr  (ent_addr),
  .ent_len   (ent_len),
  .ent_final (ent_final),
  .done      (done),
  .err       (err)
);

// File: tb/frame_walker_bench.sv
module frame_walker_bench;

  localparam int MAXE = 19;
  localparam int T_DONE = 0;
  localparam int T_OVR  = 1;
  localparam int T_LEN  = 2;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [15:0] base_in;
  logic        busy;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic        ent_valid;
  logic        rdy;
  logic [4:0]  ent_index;
  logic [1:0]  ent_role;
  logic [39:0] ent_addr;
  logic [19:0] ent_len;
  logic        ent_final;
  logic        ent_ext;
  logic        done;
  logic        err;
  logic [1:0]  err_code;

  frame_walker u_frame_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_in), .busy(busy),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .ent_valid(ent_valid), .ent_ready(rdy), .ent_index(ent_index), .ent_role(ent_role),
    .ent_addr(ent_addr), .ent_len(ent_len), .ent_final(ent_final), .ent_ext(ent_ext),
    .done(done), .err(err), .err_code(err_code)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] mem [0:1023];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:0]];

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int n_pres = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    logic [39:0] a;
    logic [19:0] l;
    bit          f;
    bit          x;
    logic [1:0]  r;
    int          i;
  } exp_t;

  exp_t exp_q[$];
  int   term;
  bit   m_busy, m_show, m_done, m_err;
  int   m_cnt, m_pos, m_base;
  logic [1:0] m_code;
  bit   rnd_mode;
  logic [7:0] lf;

  function automatic void build(input int b);
    logic [4:0] opc;
    exp_t e;
    exp_q.delete();
    opc = '0;
    term = T_OVR;
    for (int i = 0; i < MAXE; i++) begin
      logic [31:0] hw, lw, fw;
      hw = mem[(b + 4*i) & 1023];
      lw = mem[(b + 4*i + 1) & 1023];
      fw = mem[(b + 4*i + 2) & 1023];
      e.a = {hw[7:0], lw};
      e.l = fw[19:0];
      e.f = fw[30];
      e.x = fw[31];
      e.i = i;
      if (i == 0) opc = mem[int'(e.a[17:2]) & 1023][31:27];
      if (i == 0) e.r = 2'd0;
      else if (i == 1) e.r = 2'd1;
      else if (i == 2 && opc == 5'h1B) e.r = 2'd1;
      else e.r = 2'd2;
      if (i > 0 && e.l == 0) begin
        term = T_LEN;
        return;
      end
      exp_q.push_back(e);
      if (e.f) begin
        term = T_DONE;
        return;
      end
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_show = 0; m_done = 0; m_err = 0;
      m_cnt = 0; m_pos = 0; m_code = 0; m_base = 0;
    end else begin
      if (ent_valid && rdy) n_pres++;
      m_done = 0;
      m_err  = 0;
      if (!m_busy) begin
        if (start) begin
          build(int'(base_in));
          m_base = int'(base_in);
          m_busy = 1; m_pos = 0; m_cnt = 6; m_show = 0; m_code = 0;
        end
      end else if (m_show) begin
        if (rdy) begin
          m_show = 0;
          if (m_pos == exp_q.size() - 1 && term != T_LEN) begin
            m_busy = 0;
            if (term == T_DONE) m_done = 1;
            else begin m_err = 1; m_code = 2; end
          end else begin
            m_pos++;
            m_cnt = 4;
          end
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          if (m_pos >= exp_q.size()) begin
            m_busy = 0; m_err = 1; m_code = 1;
          end else m_show = 1;
        end
      end
    end
  end

  // per-cycle comparison, ready generation, watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R10", "ent_valid", ent_valid, m_show);
      if (m_show && ent_valid) begin
        chk("R2", "ent_addr", ent_addr, exp_q[m_pos].a);
        chk("R2", "ent_len", ent_len, exp_q[m_pos].l);
        chk("R2", "ent_final", ent_final, exp_q[m_pos].f);
        chk("R2", "ent_ext", ent_ext, exp_q[m_pos].x);
        chk("R4", "ent_role", ent_role, exp_q[m_pos].r);
        chk("R3", "ent_index", ent_index, exp_q[m_pos].i);
      end
      chk("R7", "done", done, m_done);
      chk(m_code == 2'd1 ? "R9" : "R8", "err", err, m_err);
      chk("R11", "busy", busy, m_busy);
      chk("R12", "err_code", err_code, m_code);
      if (mem_rd_en && m_busy && mem_rd_addr < 16'd512)
        chk("R3", "spare word read", ((int'(mem_rd_addr) - m_base) & 3) == 3, 1'b0);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      rdy = rnd_mode ? lf[0] : 1'b1;
    end else begin
      lf = 8'h5B;
      rdy = 1'b1;
    end
    if (cyc == 100000) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put_ent(input int b, input int i, input logic [39:0] a, input logic [19:0] l,
                         input bit f, input bit x);
    mem[b + 4*i]     = {24'hC3A500 ^ 24'(i * 24'h010101), a[39:32]};
    mem[b + 4*i + 1] = a[31:0];
    mem[b + 4*i + 2] = {x, f, 10'h2B7, l};
    mem[b + 4*i + 3] = 32'hFFFF_FFFF;
  endtask

  task automatic walk(input int b, input bit rnd);
    base_in  = 16'(b);
    rnd_mode = rnd;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    base_in = '0;
    rnd_mode = 1'b0;
    for (int k = 0; k < 1024; k++) mem[k] = 32'h5A00_0000 ^ (k * 32'h0001_0203);
    // command blocks: copy at word 608, single parity at 600, dual parity at 604
    mem[600] = {5'h1A, 27'h0123456};
    mem[604] = {5'h1B, 27'h7654321};
    mem[608] = {5'h08, 27'h0000ABC};

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "ent_valid", ent_valid, 1'b0);
    chk("R1", "busy", busy, 1'b0);
    chk("R1", "done", done, 1'b0);
    chk("R1", "err", err, 1'b0);
    chk("R1", "mem_rd_en", mem_rd_en, 1'b0);
    chk("R1", "err_code", err_code, 2'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after release", {busy, ent_valid, mem_rd_en}, 3'b000);

    // single parity table (R5 opcode 0x1A, entry 2 is a source), upper addr bits of cmd ptr ignored
    put_ent(0, 0, 40'h3C_0000_0960, 20'd64, 0, 0);
    put_ent(0, 1, 40'h12_3456_7800, 20'd4096, 0, 0);
    put_ent(0, 2, 40'hAB_0000_1000, 20'd4096, 0, 1);
    put_ent(0, 3, 40'h01_FFFF_FFF0, 20'hFFFFF, 1, 0);
    walk(0, 0);

    // dual parity table, stalled consumer (R4, R6)
    put_ent(40, 0, 40'h00_0000_0970, 20'd128, 0, 0);
    put_ent(40, 1, 40'h5A_0000_2000, 20'd512, 0, 0);
    put_ent(40, 2, 40'h5A_0000_3000, 20'd512, 0, 0);
    put_ent(40, 3, 40'hFF_8000_0000, 20'd512, 0, 0);
    put_ent(40, 4, 40'h00_0000_0004, 20'd1, 1, 1);
    walk(40, 1);

    // copy table, opcode 0x08
    put_ent(60, 0, 40'h77_0000_0980, 20'd32, 0, 0);
    put_ent(60, 1, 40'h00_1111_0000, 20'd256, 0, 0);
    put_ent(60, 2, 40'h00_2222_0000, 20'd256, 1, 1);
    walk(60, 1);

    // R8 overrun: 19 entries, none final
    for (int i = 0; i < MAXE; i++)
      put_ent(100, i, (i == 0) ? 40'h00_0000_0970 : 40'(40'h10_0000_0000 + i * 40'h100), 20'(i + 8), 0, 0);
    walk(100, 0);
    chk("R12", "err_code held after overrun", err_code, 2'd2);

    // R9 zero length at entry 3 of dual parity table
    put_ent(200, 0, 40'h00_0000_0970, 20'd16, 0, 0);
    put_ent(200, 1, 40'h00_0000_4000, 20'd8, 0, 0);
    put_ent(200, 2, 40'h00_0000_5000, 20'd8, 0, 0);
    put_ent(200, 3, 40'h00_0000_6000, 20'd0, 0, 0);
    put_ent(200, 4, 40'h00_0000_7000, 20'd8, 1, 0);
    walk(200, 1);
    chk("R9", "err_code held after zero length", err_code, 2'd1);

    // command entry alone, final, zero length allowed on entry 0
    put_ent(220, 0, 40'h00_0000_0960, 20'd0, 1, 0);
    walk(220, 0);

    // R11 start ignored while busy
    put_ent(240, 0, 40'h00_0000_0960, 20'd64, 0, 0);
    put_ent(240, 1, 40'h00_0000_8000, 20'd64, 0, 0);
    put_ent(240, 2, 40'h00_0000_9000, 20'd64, 0, 0);
    put_ent(240, 3, 40'h00_0000_A000, 20'd64, 1, 0);
    n_pres = 0;
    base_in = 16'd240;
    rnd_mode = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (8) @(negedge clk);
    base_in = 16'd0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R11", "entries presented", n_pres, 4);

    // longest legal table: final on the last allowed entry
    for (int i = 0; i < MAXE; i++)
      put_ent(300, i, (i == 0) ? 40'h00_0000_0970 : 40'(40'h20_0000_0000 + i * 40'h40), 20'(i * 3 + 1), i == MAXE - 1, 0);
    walk(300, 1);
    chk("R7", "err_code after full table", err_code, 2'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule